// File: doc/BRIEF.md
# Three-Phase Waveform Generator

This block drives the six gate signals of a three-phase inverter bridge from triangular-wave modulation timing. A carrier counter runs down from a programmed period. Each time it passes zero it raises a one-cycle carrier interrupt and fires one one-shot timer per phase (U, V, W). Each one-shot has its own programmed width. The edges of its pulse toggle that phase's output level, so the width and the carrier period together set how long each phase stays high and low.

Each phase has a polarity buffer bit. Software may rewrite it at any point in a carrier period. Its value is copied into the phase level only at the next carrier zero event, which gives a clean, period-aligned change. A trigger-select bit chooses whether both pulse edges toggle a phase or only the falling edge. An output-enable bit gates all six outputs. Every inverted output is the complement of its positive output.

Software programs the block through a single-cycle write port. Address 0 holds the carrier period. Addresses 1, 2 and 3 hold the one-shot widths for U, V and W. Address 4 is control: bit 0 enables the outputs, bit 1 selects falling-edge-only triggering, bit 2 runs the carrier. Address 5 holds the polarity buffers: bit 0 for U, bit 1 for V, bit 2 for W. Every write takes effect on the clock edge that samples it.

Top module: `three_phase_gen`

## Requirements
- R1: During and after a synchronous reset (rst_n low), all six phase outputs and carrier_irq are 0 and all registers are cleared.
- R2: While the run bit (address 4, bit 2) is 1 and the period register holds P, the carrier counter reaches zero every P+1 cycles. carrier_irq is high for the one cycle that follows each zero.
- R3: At each carrier zero, every phase one-shot with a nonzero width W starts a pulse. The pulse is high for exactly W cycles, starting in the cycle in which carrier_irq is high.
- R4: In the cycle in which carrier_irq is high, each phase level equals the polarity buffer bit (address 5, bit 0=U, 1=V, 2=W) as it stood at the zero event. A polarity write made between zero events has no effect until the next zero.
- R5: With the trigger-select bit (address 4, bit 1) at 0, both the rising and the falling edge of a phase's pulse invert that phase's level. The rising-edge toggle appears one cycle after the carrier_irq cycle. The falling-edge toggle appears W+1 cycles after it.
- R6: With the trigger-select bit at 1, only the falling edge inverts the level. The level stays at the polarity value for W+1 cycles from the carrier_irq cycle, then flips.
- R7: A phase whose one-shot width is 0 produces no pulse. Its level holds the latched polarity for the whole carrier period.
- R8: With the enable bit (address 4, bit 0) at 0, all six outputs are 0.
- R9: With the enable bit at 1, each inverted output is the exact complement of its positive output in every cycle.
- R10: Phases V and W behave like U, each with its own width register and its own polarity bit, independent of the other phases.
- R11: With the run bit at 0, the carrier counter holds the period value and carrier_irq stays 0. When the run bit is set again, counting restarts from the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1-3 widths U/V/W, 4 control, 5 polarity) |
| wr_data | input | 16 | Register write data |
| ph_p | output | 3 | Positive phase outputs, bit 0=U, 1=V, 2=W |
| ph_n | output | 3 | Inverted phase outputs, same bit order |
| carrier_irq | output | 1 | One-cycle pulse after each carrier zero |

## Verification
carrier_irq is due one cycle after the edge at which the counter sits at zero. The phase levels take the polarity value in that same cycle. A rising-edge toggle shows one cycle later, and a falling-edge toggle shows W+1 cycles after the interrupt cycle. Every register write is visible from the edge that samples it. The bench's cycle model advances on each rising edge with the same write sampling and queues the expected outputs for that edge. The monitor pops one entry per falling edge, so every comparison lands half a cycle after the edge it predicts.

// File: rtl/tpw_pkg.sv
// Shared constants and types for the three-phase waveform generator.
// Assumes a single clock domain and a flat write-only register map.
package tpw_pkg;
    localparam int CNT_W  = 16;
    localparam int NPH    = 3;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
    localparam logic [ADDR_W-1:0] A_WID0   = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
    localparam logic [ADDR_W-1:0] A_POL    = 3'd5;

    // control register layout: bit0 enable, bit1 falling-only, bit2 run
    typedef struct packed {
        logic run;
        logic fall_only;
        logic out_en;
    } ctrl_t;
endpackage

// File: rtl/tpw_regs.sv
// Register file: carrier period, per-phase one-shot widths, control bits
// and per-phase polarity buffers. Write-only, one write per cycle.
// Assumes the width registers occupy consecutive addresses from A_WID0.
module tpw_regs
    import tpw_pkg::*;
#(
    parameter int W   = CNT_W,
    parameter int NP  = NPH,
    parameter int AW  = ADDR_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [W-1:0]          wr_data,
    output logic [W-1:0]          period,
    output logic [NP-1:0][W-1:0]  width,
    output ctrl_t                 ctrl,
    output logic [NP-1:0]         pol_buf
);
    // period, control and polarity registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period  <= '0;
            ctrl    <= '0;
            pol_buf <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PERIOD) period  <= wr_data;
            if (wr_addr == A_CTRL)   ctrl    <= ctrl_t'(wr_data[2:0]);
            if (wr_addr == A_POL)    pol_buf <= wr_data[NP-1:0];
        end
    end

    // one width register per phase
    for (genvar i = 0; i < NP; i++) begin : g_wid
        localparam logic [AW-1:0] MY_ADDR = A_WID0 + AW'(i);
        always_ff @(posedge clk) begin
            if (!rst_n)                           width[i] <= '0;
            else if (wr_en && wr_addr == MY_ADDR) width[i] <= wr_data;
        end
    end
endmodule

// File: rtl/tpw_carrier.sv
// Carrier down-counter. While stopped it holds the period value. While
// running it counts down and reloads the period after reaching zero.
// zero_evt is combinational; irq is its registered copy.
module tpw_carrier #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] period,
    output logic         zero_evt,
    output logic         irq
);
    logic [W-1:0] cnt;

    assign zero_evt = run && (cnt == '0);

    // counter: load while stopped, count down and reload while running
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!run)     cnt <= period;
        else if (zero_evt) cnt <= period;
        else               cnt <= cnt - 1'b1;
    end

    // one-cycle interrupt following each zero event
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= zero_evt;
    end
endmodule

// File: rtl/tpw_oneshot.sv
// Per-phase one-shot. A start loads the width. The pulse is high while
// the remaining count is nonzero, so a width of 0 gives no pulse.
module tpw_oneshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] width,
    output logic         pulse
);
    logic [W-1:0] remain;

    assign pulse = (remain != '0);

    // remaining pulse length: load on start, then drain to zero
    always_ff @(posedge clk) begin
        if (!rst_n)     remain <= '0;
        else if (start) remain <= width;
        else if (pulse) remain <= remain - 1'b1;
    end
endmodule

// File: rtl/tpw_phase.sv
// Phase level logic. It detects pulse edges and toggles the level on the
// selected edges. At a carrier zero it loads the level from the polarity
// buffer; the zero event takes priority over a toggle. It drives the
// gated positive and complementary outputs.
module tpw_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_evt,
    input  logic pulse,
    input  logic pol_bit,
    input  logic fall_only,
    input  logic out_en,
    output logic lvl,
    output logic out_p,
    output logic out_n
);
    logic pulse_q;
    logic rise, fall, toggle;

    assign rise   = pulse && !pulse_q;
    assign fall   = !pulse && pulse_q;
    assign toggle = fall_only ? fall : (rise || fall);

    // previous pulse value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse;
    end

    // phase level: polarity load at zero, toggle on selected edges
    always_ff @(posedge clk) begin
        if (!rst_n)        lvl <= 1'b0;
        else if (zero_evt) lvl <= pol_bit;
        else if (toggle)   lvl <= !lvl;
    end

    assign out_p = out_en && lvl;
    assign out_n = out_en && !lvl;
endmodule

// File: rtl/three_phase_gen.sv
// Top of the three-phase waveform generator. Ties together the register
// file, the carrier counter and, for each phase, a one-shot and an
// output stage. Assumes one clock and a synchronous active-low reset.
module three_phase_gen
    import tpw_pkg::*;
#(
    parameter int CW  = CNT_W,
    parameter int NP  = NPH,
    parameter int AW  = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    output logic [NP-1:0] ph_p,
    output logic [NP-1:0] ph_n,
    output logic          carrier_irq
);
    logic [CW-1:0]          period;
    logic [NP-1:0][CW-1:0]  os_width;
    ctrl_t                  ctrl_q;
    logic [NP-1:0]          pol_buf;
    logic                   zero_evt;
    logic [NP-1:0]          os_pulse;
    logic [NP-1:0]          ph_lvl;
    logic                   out_en_w;
    logic                   run_w;

    assign out_en_w = ctrl_q.out_en;
    assign run_w    = ctrl_q.run;

    tpw_regs #(.W(CW), .NP(NP), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .period  (period),
        .width   (os_width),
        .ctrl    (ctrl_q),
        .pol_buf (pol_buf)
    );

    tpw_carrier #(.W(CW)) u_carrier (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .period   (period),
        .zero_evt (zero_evt),
        .irq      (carrier_irq)
    );

    for (genvar i = 0; i < NP; i++) begin : g_ph
        tpw_oneshot #(.W(CW)) u_os (
            .clk   (clk),
            .rst_n (rst_n),
            .start (zero_evt),
            .width (os_width[i]),
            .pulse (os_pulse[i])
        );
        tpw_phase u_out (
            .clk       (clk),
            .rst_n     (rst_n),
            .zero_evt  (zero_evt),
            .pulse     (os_pulse[i]),
            .pol_bit   (pol_buf[i]),
            .fall_only (ctrl_q.fall_only),
            .out_en    (out_en_w),
            .lvl       (ph_lvl[i]),
            .out_p     (ph_p[i]),
            .out_n     (ph_n[i])
        );
    end
endmodule

// File: rtl/tpw_checker.sv
// Assertion checker for three_phase_gen, attached through bind.
module tpw_checker #(
    parameter int CW = 16,
    parameter int NP = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  carrier_irq,
    input logic [NP-1:0]         ph_p,
    input logic [NP-1:0]         ph_n,
    input logic                  out_en,
    input logic                  run,
    input logic                  zero_evt,
    input logic [NP-1:0]         pulse,
    input logic [NP-1:0][CW-1:0] width,
    input logic [NP-1:0]         pol_buf,
    input logic [NP-1:0]         lvl
);
    // R9: enabled outputs are complementary
    a_r9_complement: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> (ph_n == ~ph_p));

    // R8: disabled outputs are all low
    a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (ph_p == '0 && ph_n == '0));

    // R11: no interrupt unless the carrier ran in the previous cycle
    a_r11_no_irq_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> !carrier_irq);

    // R2: every zero event is followed by the interrupt
    a_r2_irq_after_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |=> carrier_irq);

    // R4: in the interrupt cycle the levels equal the latched polarity
    a_r4_pol_latched: assert property (@(posedge clk) disable iff (!rst_n)
        carrier_irq |-> (lvl == $past(pol_buf)));

    for (genvar i = 0; i < NP; i++) begin : g_chk
        // R3: a nonzero width starts a pulse after the zero event
        a_r3_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
            (zero_evt && width[i] != '0) |=> pulse[i]);
        // R7: a zero width never produces a pulse
        a_r7_zero_width: assert property (@(posedge clk) disable iff (!rst_n)
            (zero_evt && width[i] == '0) |=> !pulse[i]);
    end
endmodule

bind three_phase_gen tpw_checker #(.CW(CW), .NP(NP)) u_tpw_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .carrier_irq (carrier_irq),
    .ph_p        (ph_p),
    .ph_n        (ph_n),
    .out_en      (out_en_w),
    .run         (run_w),
    .zero_evt    (zero_evt),
    .pulse       (os_pulse),
    .width       (os_width),
    .pol_buf     (pol_buf),
    .lvl         (ph_lvl)
);

// File: tb/tb_three_phase_gen.sv
`timescale 1ns/1ps
module tb_three_phase_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  ph_p, ph_n;
    logic        carrier_irq;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    three_phase_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ph_p(ph_p), .ph_n(ph_n), .carrier_irq(carrier_irq)
    );

    // expected item produced by the driver-side model
    typedef struct packed {
        logic [2:0] p;
        logic [2:0] n;
        logic       irq;
        logic       rst;
        logic       en;
        logic       fall;
        logic       ran;
        logic [2:0] wz;
        logic [2:0] pol_at_zero;
    } exp_t;
    exp_t sbq[$];

    // requirement model state
    logic [15:0]      m_period, m_cnt;
    logic [2:0][15:0] m_wid, m_os;
    logic [2:0]       m_pq, m_lvl, m_pol;
    logic             m_en, m_fall, m_run, m_irq;
    logic             zero, pulse_old, tog;
    exp_t             e;

    // model: advances one step per rising edge and queues the outputs due
    always @(posedge clk) begin
        if (!rst_n) begin
            m_period = '0; m_cnt = '0; m_wid = '0; m_os = '0;
            m_pq = '0; m_lvl = '0; m_pol = '0;
            m_en = 0; m_fall = 0; m_run = 0; m_irq = 0;
            e = '0;
            e.rst = 1'b1;
            sbq.push_back(e);
        end else begin
            e = '0;
            e.ran = m_run;
            zero = m_run && (m_cnt == 16'd0);
            e.pol_at_zero = m_pol;
            for (int i = 0; i < 3; i++) begin
                pulse_old = (m_os[i] != 16'd0);
                tog = m_fall ? (!pulse_old && m_pq[i])
                             : (pulse_old != m_pq[i]);
                if (zero)      m_lvl[i] = m_pol[i];
                else if (tog)  m_lvl[i] = !m_lvl[i];
                m_pq[i] = pulse_old;
                if (zero)           m_os[i] = m_wid[i];
                else if (pulse_old) m_os[i] = m_os[i] - 16'd1;
            end
            m_irq = zero;
            if (!m_run || zero) m_cnt = m_period;
            else                m_cnt = m_cnt - 16'd1;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_period = wr_data;
                    3'd1: m_wid[0] = wr_data;
                    3'd2: m_wid[1] = wr_data;
                    3'd3: m_wid[2] = wr_data;
                    3'd4: begin
                        m_en = wr_data[0]; m_fall = wr_data[1]; m_run = wr_data[2];
                    end
                    3'd5: m_pol = wr_data[2:0];
                    default: ;
                endcase
            end
            e.en   = m_en;
            e.fall = m_fall;
            e.irq  = m_irq;
            e.p    = m_en ? m_lvl : 3'b000;
            e.n    = m_en ? ~m_lvl : 3'b000;
            for (int i = 0; i < 3; i++) e.wz[i] = (m_wid[i] == 16'd0);
            sbq.push_back(e);
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string phase_tag(exp_t x, int i);
        if (x.rst)   return "R1";
        if (!x.en)   return "R8";
        if (x.wz[i]) return "R7";
        if (i > 0)   return "R10";
        if (x.fall)  return "R6";
        return "R3,R5";
    endfunction

    // monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        if (sbq.size() > 0) begin
            exp_t x;
            x = sbq.pop_front();
            check(x.rst ? "R1" : (x.ran ? "R2" : "R11"),
                  int'(carrier_irq), int'(x.irq));
            for (int i = 0; i < 3; i++) begin
                check(phase_tag(x, i), int'(ph_p[i]), int'(x.p[i]));
                check(x.rst ? "R1" : (x.en ? "R9" : "R8"), int'(ph_n[i]), int'(x.n[i]));
            end
            if (!x.rst && x.irq && x.en)
                check("R4", int'(ph_p), int'(x.pol_at_zero));
        end
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(5);
        // both-edge triggering, mixed widths incl. zero width on W (R5, R7, R10)
        wr(3'd0, 16'd9);
        wr(3'd1, 16'd3);
        wr(3'd2, 16'd5);
        wr(3'd3, 16'd0);
        wr(3'd5, 16'b101);
        wr(3'd4, 16'd5);
        idle(40);
        // polarity change mid-period applies at next zero (R4)
        idle(3);
        wr(3'd5, 16'b010);
        idle(30);
        // falling-edge-only triggering (R6)
        wr(3'd4, 16'd7);
        idle(30);
        // new widths change level durations (R3, R10)
        wr(3'd1, 16'd7);
        wr(3'd3, 16'd2);
        idle(30);
        // outputs disabled (R8), then re-enabled (R9)
        wr(3'd4, 16'd6);
        idle(20);
        wr(3'd4, 16'd7);
        // shorter carrier period (R2)
        wr(3'd0, 16'd4);
        wr(3'd1, 16'd2);
        idle(20);
        // stop the carrier, then restart with a long period (R11)
        wr(3'd4, 16'd1);
        idle(15);
        wr(3'd0, 16'd20);
        wr(3'd4, 16'd5);
        idle(50);
        // reset mid-run (R1)
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(10);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    // watchdog: a hang counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            misses++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end
endmodule